// File: doc/BRIEF.md
# Dual Three-Port Parallel I/O Controller

This block is a slave peripheral on an 8-bit I/O bus. It decodes a 16-byte address window and holds two identical groups of parallel ports. Each group has three 8-bit ports, called A, B and C, plus one control register, so the block serves 48 lines in all. Every line drives a tri-state pad through an output value and an output-enable.

Software writes a mode-set word into a group's control register to choose the direction of each port. Ports A and B switch direction as whole bytes. Port C switches direction separately for each 4-bit half. A write to a port offset loads that port's output latch. A read of a port offset returns the pin levels after a two-flop synchroniser. A mode-set write also clears the output latches of its group.

Offsets 8 to 15 are reserved for a separate interrupt block, and this block does not respond to them.

Top module: `par_port_pair`

## Requirements
- R1: After reset, all 48 lines are outputs (`pad_oe` all ones) driving 0, and both control registers read 0x80.
- R2: Group g (g = 0 or 1) places port A at offset 4g, port B at offset 4g+1, port C at offset 4g+2 and its control register at offset 4g+3.
- R3: A control write with bit 7 set loads that group's direction. Bit 4 set makes port A an input. Bit 1 set makes port B an input. Bit 3 set makes port C bits 7..4 inputs. Bit 0 set makes port C bits 3..0 inputs. A cleared bit makes that port or half an output. An input line has its `pad_oe` bit at 0.
- R4: A mode-set write clears all 24 output latches of its own group to 0 and leaves the other group's latches unchanged.
- R5: A port write loads all 8 latch bits, and `pad_out` shows them whatever the direction. Only output bits assert `pad_oe`, and the write does not change direction.
- R6: A port read returns the pin levels for all 8 bits, inputs and outputs alike, through two flops. A pin change made before a rising edge does not show in the read after that one edge. It does show after the second edge.
- R7: A control register read returns the last mode-set word written to it, including bit 7.
- R8: A control write with bit 7 clear has no effect on direction, latches or the control readback.
- R9: Writes to offsets 8 to 15 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte offset within the window |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pad_in | input | 48 | Pin levels; group g port p bit b is index 24g+8p+b |
| pad_out | output | 48 | Output latch values, same indexing |
| pad_oe | output | 48 | Output enable per line, 1 drives the pad |

## Verification
The assertions assume that `addr`, `wr_en` and `wdata` are stable around each rising edge and hold defined values once reset is released. They also assume that reads have no side effects, so a read may occur in any cycle. The bench changes every bus input and pin level on the falling edge, and it keeps `wr_en` low while reset is active. It models the pads so that each pin reads back the latch when that line is enabled and a bench-chosen level when it is not.

// File: rtl/par_port_pair.sv
module par_port_pair #(
  parameter int GROUPS = 2,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  input  logic [GROUPS*24-1:0]       pad_in,
  output logic [GROUPS*24-1:0]       pad_out,
  output logic [GROUPS*24-1:0]       pad_oe
);
  localparam int GW    = ADDR_W - 2;
  localparam int GBITS = 24;
  localparam int LINES = GROUPS * GBITS;

  logic [LINES-1:0] sync1_q, sync2_q;
  logic [7:0]       ctl_q [GROUPS];
  logic [GBITS-1:0] lat_q [GROUPS];

  wire [GW-1:0] grp    = addr[ADDR_W-1:2];
  wire [1:0]    sub    = addr[1:0];
  wire          in_win = ({{(32-GW){1'b0}}, grp} < 32'(GROUPS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    wire hit = wr_en && in_win && (grp == GW'(g));
    wire [7:0] c = ctl_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[g] <= 8'h80;
        lat_q[g] <= '0;
      end else if (hit && sub == 2'd3) begin
        if (wdata[7]) begin
          ctl_q[g] <= wdata;
          lat_q[g] <= '0;
        end
      end else if (hit) begin
        lat_q[g][8*sub +: 8] <= wdata;
      end
    end

    assign pad_out[g*GBITS +: GBITS] = lat_q[g];
    assign pad_oe[g*GBITS +: GBITS]  = {{4{~c[3]}}, {4{~c[0]}}, {8{~c[1]}}, {8{~c[4]}}};

    a_r4_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(4*g+3) && wdata[7]) |=> (pad_out[g*GBITS +: GBITS] == '0));

    a_r3_dir_from_word: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(4*g+3) && wdata[7]) |=>
        (pad_oe[g*GBITS +: 8] == {8{!$past(wdata[4])}}) &&
        (pad_oe[g*GBITS+8 +: 8] == {8{!$past(wdata[1])}}) &&
        (pad_oe[g*GBITS+16 +: 4] == {4{!$past(wdata[0])}}) &&
        (pad_oe[g*GBITS+20 +: 4] == {4{!$past(wdata[3])}}));

    a_r8_plain_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(4*g+3) && !wdata[7]) |=>
        $stable(pad_oe[g*GBITS +: GBITS]) && $stable(pad_out[g*GBITS +: GBITS]));

    for (genvar p = 0; p < 3; p++) begin : g_port
      a_r5_port_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4*g+p)) |=>
          (pad_out[g*GBITS+8*p +: 8] == $past(wdata)) && $stable(pad_oe));
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int g = 0; g < GROUPS; g++) begin
      if (in_win && grp == GW'(g)) begin
        if (sub == 2'd3) rdata = ctl_q[g];
        else             rdata = sync2_q[g*GBITS + 8*int'(sub) +: 8];
      end
    end
  end

  a_r9_high_window_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_win) |=> $stable(pad_out) && $stable(pad_oe));

endmodule

// File: tb/sim_par_port_pair.sv
module sim_par_port_pair;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = 0;
  logic        wr_en = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [47:0] pad_in, pad_out, pad_oe;
  logic [47:0] ext = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign pad_in = (pad_out & pad_oe) | (ext & ~pad_oe);

  par_port_pair u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic test_reset();
    logic [7:0] d;
    chk("R1 oe", pad_oe, {48{1'b1}});
    chk("R1 out", pad_out, 48'h0);
    rd(4'd3, d); chk("R1 ctl0", {40'h0, d}, 48'h80);
    rd(4'd7, d); chk("R1 ctl1", {40'h0, d}, 48'h80);
  endtask

  task automatic test_port_writes();
    logic [7:0] d;
    wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hF0);
    wr(4, 8'h11); wr(5, 8'h22); wr(6, 8'h33);
    chk("R2 R5 map", pad_out, 48'h332211_F03CA5);
    repeat (2) @(negedge clk);
    rd(0, d); chk("R6 out readback", {40'h0, d}, 48'hA5);
    rd(6, d); chk("R6 out readback g1", {40'h0, d}, 48'h33);
  endtask

  task automatic test_modeset();
    logic [7:0] d;
    wr(3, 8'h92);
    chk("R3 g0 A B in", pad_oe[23:0], 24'hFF0000);
    chk("R4 g0 cleared", pad_out[23:0], 24'h0);
    chk("R4 g1 kept", pad_out[47:24], 24'h332211);
    rd(3, d); chk("R7 ctl0", {40'h0, d}, 48'h92);
    wr(7, 8'h89);
    chk("R3 g1 C in", pad_oe[47:24], 24'h00FFFF);
    wr(7, 8'h81);
    chk("R3 C low half", pad_oe[47:40], 8'hF0);
    wr(7, 8'h88);
    chk("R3 C high half", pad_oe[47:40], 8'h0F);
    chk("R4 g0 kept", pad_out[23:0], 24'h0);
  endtask

  task automatic test_input_sync();
    logic [7:0] d;
    @(negedge clk); ext[7:0] = 8'h5A;
    rd(0, d); chk("R6 one edge old", {40'h0, d}, 48'h00);
    rd(0, d); chk("R6 two edges new", {40'h0, d}, 48'h5A);
    wr(0, 8'hFF);
    chk("R5 latch on input", pad_out[7:0], 8'hFF);
    chk("R5 oe unchanged", pad_oe[7:0], 8'h00);
    repeat (2) @(negedge clk);
    rd(0, d); chk("R6 pin not latch", {40'h0, d}, 48'h5A);
  endtask

  task automatic test_plain_ctl();
    logic [7:0] d;
    logic [47:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    wr(3, 8'h10);
    chk("R8 oe", pad_oe, oe0);
    chk("R8 out", pad_out, out0);
    rd(3, d); chk("R8 ctl", {40'h0, d}, 48'h92);
  endtask

  task automatic test_high_window();
    logic [7:0] d;
    logic [47:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    wr(8, 8'h55); wr(15, 8'hAA); wr(11, 8'h80);
    chk("R9 out", pad_out, out0);
    chk("R9 oe", pad_oe, oe0);
    rd(8, d);  chk("R9 read 8", {40'h0, d}, 48'h0);
    rd(12, d); chk("R9 read 12", {40'h0, d}, 48'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_port_writes();
    test_modeset();
    test_input_sync();
    test_plain_ctl();
    test_high_window();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule